// File: doc/BRIEF.md
# Variable Lane Blend Unit

A vector execution unit that builds a 256-bit result one 32-bit lane at a time. For each lane it takes either the first source or the second source. The choice comes from the top bit of the matching lane of a mask operand. Three encoding forms are supported, and they differ in how the upper 128 bits are treated:

- The destructive 128-bit form keeps the upper half of the destination.
- The non-destructive 128-bit form clears the upper half.
- The 256-bit form blends all eight lanes.

The unit also decodes the mask register number from an immediate byte. It reports that number so that an external register file can return the mask value in the same cycle. It also flags encodings that must raise an invalid-opcode condition. An invalid encoding never produces a destination write.

All operand values, the form select and the encoding bits arrive with a valid strobe. The result, write-enable, invalid-opcode flag and result-valid pulse are registered, and appear one clock after the strobe. The mask register number is combinational from the immediate, the form and the mode input. Lane data is moved bit for bit, so NaN and denormal patterns pass through unchanged.

Top module: `lane_blend_unit`

## Requirements
- R1: For each blended lane i (bits 32i+31:32i), the result lane equals the first-source lane when mask bit 32i+31 is 0, and the second-source lane when that bit is 1. The other 31 bits of each mask lane have no effect.
- R2: With form code 2 (256-bit), all eight lanes are blended independently by the R1 rule.
- R3: With form code 1 (non-destructive 128-bit), lanes 0 to 3 are blended and result bits 255:128 are zero.
- R4: With form code 0 (destructive 128-bit), lanes 0 to 3 are blended and result bits 255:128 equal first-source bits 255:128. The mask register number output is 0 whatever the immediate.
- R5: With form codes 1 and 2, the mask register number equals immediate bits 7:4. Immediate bits 3:0 have no effect.
- R6: When the 32-bit-mode input is high, bit 3 of the mask register number is 0, so only registers 0 to 7 can be named.
- R7: The invalid-opcode flag is set one cycle after a valid operation in any of these cases: W set with form 1 or 2; the extended prefix present with form 0; or form code 3. In that cycle the write-enable is 0 and the result is zero. W has no effect on form 0, and the prefix input has no effect on forms 1 and 2.
- R8: The result, the write-enable and the result-valid pulse appear on the clock edge after a valid strobe. With no strobe, the write-enable and result-valid are 0 on the next cycle.
- R9: While reset is active (active-low), the result, write-enable, result-valid and invalid-opcode outputs are all zero.
- R10: Lane data is copied bit-exactly, including NaN, negative-zero and denormal patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| form | input | 2 | 0 destructive 128, 1 non-destructive 128, 2 256-bit, 3 reserved |
| w_bit | input | 1 | W bit of the extended prefix |
| ext_prefix | input | 1 | Extended prefix present |
| mode32 | input | 1 | Executing in 32-bit mode |
| imm8 | input | 8 | Immediate byte |
| src_a | input | 256 | First source (destination for form 0) |
| src_b | input | 256 | Second source |
| sel_vec | input | 256 | Mask operand |
| mask_idx | output | 4 | Decoded mask register number |
| res_valid | output | 1 | Result valid pulse |
| wr_en | output | 1 | Destination write-enable |
| ill_op | output | 1 | Invalid-opcode flag |
| result | output | 256 | Blended destination value |

## Verification
The assertions check the following on every cycle:

- the invalid-opcode flag and the write-enable are never high together, and a flagged result is zero;
- result-valid follows the strobe;
- a cleared or preserved upper half matches its form;
- bit 3 of the mask register number is clear in 32-bit mode;
- changing only the don't-care mask bits or the low immediate bits leaves the outputs unchanged.

Only the bench scenarios can show that each lane takes the correct source for mixed masks, that special floating-point patterns survive untouched, and that every invalid-encoding combination is caught while the harmless ones are not.

// File: rtl/lane_blend_unit.sv
module lane_blend_unit #(
  parameter int LANE_W = 32,
  parameter int VLEN   = 256,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       form,
  input  logic             w_bit,
  input  logic             ext_prefix,
  input  logic             mode32,
  input  logic [7:0]       imm8,
  input  logic [VLEN-1:0]  src_a,
  input  logic [VLEN-1:0]  src_b,
  input  logic [VLEN-1:0]  sel_vec,
  output logic [IDX_W-1:0] mask_idx,
  output logic             res_valid,
  output logic             wr_en,
  output logic             ill_op,
  output logic [VLEN-1:0]  result
);
  localparam int LANES = VLEN / LANE_W;
  localparam int HALF  = LANES / 2;
  localparam logic [1:0] F_LEG   = 2'd0;
  localparam logic [1:0] F_ND128 = 2'd1;
  localparam logic [1:0] F_ND256 = 2'd2;
  localparam logic [1:0] F_RSV   = 2'd3;

  logic [LANES-1:0] pick;
  logic [VLEN-1:0]  blend_d;
  logic             bad;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mixed;
    assign pick[g] = sel_vec[g*LANE_W + LANE_W-1];
    assign mixed   = pick[g] ? src_b[g*LANE_W +: LANE_W] : src_a[g*LANE_W +: LANE_W];
    if (g < HALF) begin : g_lo
      assign blend_d[g*LANE_W +: LANE_W] = mixed;
    end else begin : g_hi
      assign blend_d[g*LANE_W +: LANE_W] =
        (form == F_ND256) ? mixed :
        (form == F_LEG)   ? src_a[g*LANE_W +: LANE_W] : '0;
    end
  end

  assign mask_idx = (form == F_LEG) ? '0 : {imm8[7] & ~mode32, imm8[6:4]};

  assign bad = (form == F_RSV) ||
               ((form == F_LEG) && ext_prefix) ||
               ((form == F_ND128 || form == F_ND256) && w_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      wr_en     <= 1'b0;
      ill_op    <= 1'b0;
      result    <= '0;
    end else begin
      res_valid <= in_valid;
      wr_en     <= in_valid && !bad;
      ill_op    <= in_valid && bad;
      if (in_valid) result <= bad ? '0 : blend_d;
    end
  end

  assert_no_write_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ill_op |-> (!wr_en && result == '0));

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(in_valid));

  assert_upper_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == F_ND128) |=> (result[VLEN-1:VLEN/2] == '0));

  assert_upper_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form == F_LEG && !ext_prefix) |=>
      (wr_en && result[VLEN-1:VLEN/2] == $past(src_a[VLEN-1:VLEN/2])));

  assert_low_reg_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode32 |-> !mask_idx[IDX_W-1]);

  assert_imm_low_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (form == $past(form) && mode32 == $past(mode32) &&
     imm8[7:4] == $past(imm8[7:4]) && imm8[3:0] != $past(imm8[3:0]))
      |-> mask_idx == $past(mask_idx));

  assert_mask_dontcare_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(in_valid) && form == $past(form) && w_bit == $past(w_bit) &&
     ext_prefix == $past(ext_prefix) && src_a == $past(src_a) &&
     src_b == $past(src_b) && pick == $past(pick) && sel_vec != $past(sel_vec))
      |=> result == $past(result));
endmodule

// File: tb/test_lane_blend_unit.sv
module test_lane_blend_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   form;
  logic         w_bit, ext_prefix, mode32;
  logic [7:0]   imm8;
  logic [255:0] src_a, src_b, sel_vec;
  logic [3:0]   mask_idx;
  logic         res_valid, wr_en, ill_op;
  logic [255:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_blend_unit i_lane_blend_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form(form), .w_bit(w_bit),
    .ext_prefix(ext_prefix), .mode32(mode32), .imm8(imm8), .src_a(src_a),
    .src_b(src_b), .sel_vec(sel_vec), .mask_idx(mask_idx), .res_valid(res_valid),
    .wr_en(wr_en), .ill_op(ill_op), .result(result));

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] expect_blend(input logic [1:0] f, input logic [255:0] a,
                                                input logic [255:0] b, input logic [255:0] m);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] la, lb;
      la = a[i*32 +: 32];
      lb = b[i*32 +: 32];
      if (i < 4 || f == 2'd2) r[i*32 +: 32] = m[i*32+31] ? lb : la;
      else if (f == 2'd0)     r[i*32 +: 32] = la;
      else                    r[i*32 +: 32] = '0;
    end
    return r;
  endfunction

  task automatic issue(input logic [1:0] f, input logic w, input logic x, input logic m32,
                       input logic [7:0] im, input logic [255:0] a, input logic [255:0] b,
                       input logic [255:0] m);
    @(negedge clk);
    in_valid = 1'b1; form = f; w_bit = w; ext_prefix = x; mode32 = m32;
    imm8 = im; src_a = a; src_b = b; sel_vec = m;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic blend_case(input string req, input logic [1:0] f, input logic [255:0] a,
                            input logic [255:0] b, input logic [255:0] m);
    logic [255:0] e;
    e = expect_blend(f, a, b, m);
    issue(f, 1'b0, (f != 2'd0), 1'b0, 8'h30, a, b, m);
    check(result == e, req, result, e);
    check(wr_en && res_valid && !ill_op, {req, " wr_en"}, {253'd0, wr_en, res_valid, ill_op}, 256'd6);
  endtask

  function automatic logic [255:0] lanes(input logic [15:0] tag);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = {tag, 8'(i), 8'h5A};
    return v;
  endfunction

  function automatic logic [255:0] mask_of(input logic [7:0] top, input logic [30:0] rest);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = {top[i], rest};
    return v;
  endfunction

  task automatic test_reset();
    rst_n = 1'b0; in_valid = 1'b0; form = 2'd0; w_bit = 1'b0; ext_prefix = 1'b0;
    mode32 = 1'b0; imm8 = 8'h00; src_a = '0; src_b = '0; sel_vec = '0;
    repeat (3) @(posedge clk);
    #1;
    check(result == '0 && !wr_en && !res_valid && !ill_op, "R9 reset",
          {252'd0, wr_en, res_valid, ill_op, 1'b0} | result, 256'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic test_wide();
    blend_case("R2 mixed", 2'd2, lanes(16'hAAAA), lanes(16'h5555), mask_of(8'b1010_0110, 31'h0));
    blend_case("R2 all-b", 2'd2, lanes(16'h1111), lanes(16'h2222), mask_of(8'hFF, 31'h0));
    blend_case("R1 dontcare", 2'd2, lanes(16'h3333), lanes(16'h4444), mask_of(8'b0101_1000, 31'h7FFF_FFFF));
  endtask

  task automatic test_narrow();
    blend_case("R3", 2'd1, lanes(16'hC0DE), lanes(16'hBEEF), mask_of(8'hFF, 31'h1234));
    blend_case("R4", 2'd0, lanes(16'hDEAD), lanes(16'hF00D), mask_of(8'b1100_1001, 31'h0));
  endtask

  task automatic test_special_values();
    logic [255:0] a, b, m, e;
    a = {32'h7FC0_0001, 32'h8000_0000, 32'h0000_0001, 32'hFF80_0000,
         32'h7F80_0000, 32'h0040_0000, 32'hFFFF_FFFF, 32'h8000_0001};
    b = ~a;
    m = mask_of(8'b0011_1100, 31'h2AAA_AAAA);
    e = expect_blend(2'd2, a, b, m);
    issue(2'd2, 1'b0, 1'b1, 1'b0, 8'h00, a, b, m);
    check(result == e, "R10 bit-exact", result, e);
  endtask

  task automatic test_index();
    @(negedge clk);
    form = 2'd2; mode32 = 1'b0; imm8 = 8'hD7; #1;
    check(mask_idx == 4'hD, "R5 idx", {252'd0, mask_idx}, 256'hD);
    imm8 = 8'hD0; #1;
    check(mask_idx == 4'hD, "R5 low ignored", {252'd0, mask_idx}, 256'hD);
    mode32 = 1'b1; #1;
    check(mask_idx == 4'h5, "R6 bit7 ignored", {252'd0, mask_idx}, 256'h5);
    form = 2'd0; mode32 = 1'b0; imm8 = 8'hF3; #1;
    check(mask_idx == 4'h0, "R4 idx zero", {252'd0, mask_idx}, 256'h0);
  endtask

  task automatic fault_case(input string req, input logic [1:0] f, input logic w,
                            input logic x, input bit expect_bad);
    logic [255:0] e;
    issue(f, w, x, 1'b0, 8'h10, lanes(16'h7777), lanes(16'h8888), mask_of(8'h0F, 31'h0));
    e = expect_bad ? '0 : expect_blend(f, lanes(16'h7777), lanes(16'h8888), mask_of(8'h0F, 31'h0));
    check(ill_op == expect_bad && wr_en == !expect_bad && result == e, req, result, e);
  endtask

  task automatic test_faults();
    fault_case("R7 W on 256", 2'd2, 1'b1, 1'b1, 1'b1);
    fault_case("R7 W on nd128", 2'd1, 1'b1, 1'b1, 1'b1);
    fault_case("R7 prefix on legacy", 2'd0, 1'b0, 1'b1, 1'b1);
    fault_case("R7 reserved form", 2'd3, 1'b0, 1'b1, 1'b1);
    fault_case("R7 W ignored legacy", 2'd0, 1'b1, 1'b0, 1'b0);
    fault_case("R7 prefix ignored nd", 2'd1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic test_idle();
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check(!wr_en && !res_valid, "R8 idle", {254'd0, wr_en, res_valid}, 256'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    test_reset();
    test_wide();
    test_narrow();
    test_special_values();
    test_index();
    test_faults();
    test_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule